// File: doc/BRIEF.md
# Digit-Module Microinstruction Sequencing Controller

This block is the local control state machine of one module in a linear chain of identical digit modules. Each module keeps one digit of every active operand. Microinstructions enter the chain at the most significant module and ripple toward the least significant one. Each module executes a microinstruction in turn, staggered behind its left neighbour, instead of all modules acting in lockstep. The controller does no arithmetic. It issues an execute strobe with the microinstruction code to its own datapath and coordinates with both neighbours.

Toward the left neighbour the controller takes in a microinstruction code and a modifier. It raises an executed notice, and it waits for a permission to execute. Toward the right neighbour it forwards the code and a freshly computed modifier. It accepts the right neighbour's executed notice, and it raises its own permission to execute. Every handshake is a level-held request answered by an acknowledge pulse lasting one cycle. The rightmost module of the chain ties `last_i` high so that its right-side waits finish at once. A multiplication step reaches the controller as a repeated group of three codes: shift-left on the multiplier, multiply-add, then shift-left on the accumulator.

Top module: `digit_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset until the first request, `lack_o`, `rreq_o`, `rgo_o`, `lexec_o`, `exec_o`, `done_o`, `lgo_ack_o` and `rexec_ack_o` are all 0.
- R2: A microinstruction is accepted only in the receptive state. `lack_o` is high for exactly the cycle in which `lreq_i` is seen there, and a request raised while the controller is busy gets no acknowledge.
- R3: The forwarded modifier is computed at acceptance from the code `lop_i`, the modifier `lmod_i` and the local digits. Code 0 (pass) gives `lmod_i`. Code 1 (shift-left) gives `dig_a_i`. Code 2 (multiply-add) gives `lmod_i + dig_b_i` modulo 2^DW. Code 3 (transfer) gives `dig_b_i`.
- R4: From the cycle after acceptance, `rreq_o` stays high with `rop_o` equal to the accepted code and `rmod_o` stable, until the cycle in which `rack_i` is high.
- R5: After the first microinstruction since reset, `exec_o` stays low until the right neighbour has reported, through `rexec_i`, that it executed the previous microinstruction.
- R6: `exec_o` is high for one cycle, only while `lgo_i` is high, with `lgo_ack_o` high in the same cycle and `exec_op_o` equal to the accepted code.
- R7: After executing, the controller holds `rgo_o` high until `rgo_ack_i`. In that cycle `done_o` pulses, and the controller then returns to the receptive state.
- R8: `lexec_o` rises in the cycle after an execution and stays high until `lexec_ack_i`. It is unaffected by accepting the next microinstruction.
- R9: `rexec_ack_o` is high in the cycle `rexec_i` is first seen, and the report is held for the next execution.
- R10: With `last_i` high, `rreq_o`, `rgo_o` and `rexec_ack_o` stay low, and each right-side wait lasts one cycle. An accepted microinstruction with `lgo_i` high gives `exec_o` two cycles after acceptance and `done_o` one cycle after that.
- R11: Microinstructions issued back to back, such as the multiplication group of codes 1, 2, 1, are forwarded and executed in the order they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| last_i | input | 1 | Tie-off for the least significant module |
| dig_a_i | input | DW | Local operand digit A |
| dig_b_i | input | DW | Local operand digit B |
| lreq_i | input | 1 | Microinstruction request from the left |
| lop_i | input | 2 | Microinstruction code from the left |
| lmod_i | input | DW | Modifier from the left |
| lack_o | output | 1 | Acceptance pulse to the left |
| lgo_i | input | 1 | Permission to execute from the left |
| lgo_ack_o | output | 1 | Acknowledge of the permission |
| lexec_o | output | 1 | Executed notice to the left |
| lexec_ack_i | input | 1 | Acknowledge of the executed notice |
| rreq_o | output | 1 | Microinstruction request to the right |
| rop_o | output | 2 | Forwarded code |
| rmod_o | output | DW | Forwarded modifier |
| rack_i | input | 1 | Acceptance pulse from the right |
| rexec_i | input | 1 | Executed notice from the right |
| rexec_ack_o | output | 1 | Acknowledge of the right's notice |
| rgo_o | output | 1 | Permission to execute for the right |
| rgo_ack_i | input | 1 | Acknowledge of the permission |
| exec_o | output | 1 | Execute strobe to the local datapath |
| exec_op_o | output | 2 | Code being executed |
| done_o | output | 1 | One-cycle pulse per completed microinstruction |

## Verification
The hardest case to reach is a controller that has already accepted and forwarded its next microinstruction, holds permission from the left, and is still blocked only because the right neighbour has not reported the previous execution. The left executed notice from the last execution is also still pending at that point. The bench plays both neighbours and deliberately delays the right's executed report and the left's acknowledge. It checks that the strobe stays low until the report arrives and that the pending notice survives the new acceptance. Random codes, modifiers, digits and permission delays then run many microinstructions through the same ordering checks.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int UOP_W = 2;

  typedef enum logic [UOP_W-1:0] {
    UOP_PASS = 2'd0,
    UOP_SHL  = 2'd1,
    UOP_MADD = 2'd2,
    UOP_XFER = 2'd3
  } uop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FWD  = 2'd1,
    ST_WAIT = 2'd2,
    ST_GO   = 2'd3
  } st_e;
endpackage

// File: rtl/dsc_mod_unit.sv
module dsc_mod_unit
  import dsc_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [UOP_W-1:0] op_i,
  input  logic [DW-1:0]    mod_i,
  input  logic [DW-1:0]    dig_a_i,
  input  logic [DW-1:0]    dig_b_i,
  output logic [DW-1:0]    mod_o
);
  // modifier update selected by microinstruction code
  function automatic logic [DW-1:0] next_mod(
    input uop_e op, input logic [DW-1:0] m,
    input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW-1:0] r;
    unique case (op)
      UOP_PASS: r = m;
      UOP_SHL:  r = a;
      UOP_MADD: r = m + b;
      default:  r = b;
    endcase
    return r;
  endfunction

  assign mod_o = next_mod(uop_e'(op_i), mod_i, dig_a_i, dig_b_i);
endmodule

// File: rtl/dsc_latch.sv
module dsc_latch
  import dsc_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [UOP_W-1:0] op_i,
  input  logic [DW-1:0]    mod_i,
  output logic [UOP_W-1:0] op_o,
  output logic [DW-1:0]    mod_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_o  <= '0;
      mod_o <= '0;
    end else if (load_i) begin
      op_o  <= op_i;
      mod_o <= mod_i;
    end
  end
endmodule

// File: rtl/dsc_flags.sv
module dsc_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic last_i,
  input  logic exec_i,
  input  logic rexec_i,
  input  logic lexec_ack_i,
  output logic rexec_ack_o,
  output logic right_ready_o,
  output logic lexec_o
);
  logic rclr_q;
  logic lexec_q;

  assign rexec_ack_o   = rexec_i & ~rclr_q & ~last_i;
  assign right_ready_o = rclr_q | last_i;
  assign lexec_o       = lexec_q;

  // right neighbour has finished the previous microinstruction; true after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rclr_q <= 1'b1;
    else if (exec_i)      rclr_q <= 1'b0;
    else if (rexec_ack_o) rclr_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lexec_q <= 1'b0;
    else if (exec_i)      lexec_q <= 1'b1;
    else if (lexec_ack_i) lexec_q <= 1'b0;
  end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic last_i,
  input  logic lreq_i,
  input  logic rack_i,
  input  logic lgo_i,
  input  logic rgo_ack_i,
  input  logic right_ready_i,
  output logic accept_o,
  output logic exec_o,
  output logic done_o,
  output logic rreq_o,
  output logic rgo_o
);
  st_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    accept_o = 1'b0;
    exec_o   = 1'b0;
    done_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (lreq_i) begin
        accept_o = 1'b1;
        state_d  = ST_FWD;
      end
      ST_FWD: if (rack_i || last_i) state_d = ST_WAIT;
      ST_WAIT: if (lgo_i && right_ready_i) begin
        exec_o  = 1'b1;
        state_d = ST_GO;
      end
      default: if (rgo_ack_i || last_i) begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  assign rreq_o = (state_q == ST_FWD) && !last_i;
  assign rgo_o  = (state_q == ST_GO) && !last_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/digit_seq_ctrl.sv
module digit_seq_ctrl
  import dsc_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_i,
  input  logic [DW-1:0]    dig_a_i,
  input  logic [DW-1:0]    dig_b_i,
  input  logic             lreq_i,
  input  logic [UOP_W-1:0] lop_i,
  input  logic [DW-1:0]    lmod_i,
  output logic             lack_o,
  input  logic             lgo_i,
  output logic             lgo_ack_o,
  output logic             lexec_o,
  input  logic             lexec_ack_i,
  output logic             rreq_o,
  output logic [UOP_W-1:0] rop_o,
  output logic [DW-1:0]    rmod_o,
  input  logic             rack_i,
  input  logic             rexec_i,
  output logic             rexec_ack_o,
  output logic             rgo_o,
  input  logic             rgo_ack_i,
  output logic             exec_o,
  output logic [UOP_W-1:0] exec_op_o,
  output logic             done_o
);
  // internal events named for the checker
  logic          accept_w;
  logic          exec_w;
  logic          right_ready_w;
  logic [DW-1:0] new_mod_w;
  logic [UOP_W-1:0] op_q;

  dsc_mod_unit #(.DW(DW)) u_mod (
    .op_i(lop_i), .mod_i(lmod_i), .dig_a_i(dig_a_i), .dig_b_i(dig_b_i),
    .mod_o(new_mod_w)
  );

  dsc_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst_n(rst_n), .load_i(accept_w), .op_i(lop_i),
    .mod_i(new_mod_w), .op_o(op_q), .mod_o(rmod_o)
  );

  dsc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .last_i(last_i), .exec_i(exec_w),
    .rexec_i(rexec_i), .lexec_ack_i(lexec_ack_i), .rexec_ack_o(rexec_ack_o),
    .right_ready_o(right_ready_w), .lexec_o(lexec_o)
  );

  dsc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .last_i(last_i), .lreq_i(lreq_i),
    .rack_i(rack_i), .lgo_i(lgo_i), .rgo_ack_i(rgo_ack_i),
    .right_ready_i(right_ready_w), .accept_o(accept_w), .exec_o(exec_w),
    .done_o(done_o), .rreq_o(rreq_o), .rgo_o(rgo_o)
  );

  assign lack_o    = accept_w;
  assign exec_o    = exec_w;
  assign lgo_ack_o = exec_w;
  assign rop_o     = op_q;
  assign exec_op_o = op_q;
endmodule

// File: rtl/digit_seq_ctrl_chk.sv
module digit_seq_ctrl_chk #(
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          last_i,
  input logic          lack_o,
  input logic          lgo_i,
  input logic          lgo_ack_o,
  input logic          lexec_o,
  input logic          lexec_ack_i,
  input logic          rreq_o,
  input logic [1:0]    rop_o,
  input logic [DW-1:0] rmod_o,
  input logic          rack_i,
  input logic          rexec_ack_o,
  input logic          rgo_o,
  input logic          rgo_ack_i,
  input logic          exec_o,
  input logic          done_o,
  input logic          right_ready_w
);
  // R2
  lack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lack_o |=> !lack_o);
  // R4
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rreq_o && !rack_i) |=> (rreq_o && $stable(rop_o) && $stable(rmod_o)));
  // R5
  exec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |-> right_ready_w);
  // R6
  exec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |-> (lgo_i && lgo_ack_o));
  // R7
  go_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgo_o && !rgo_ack_i) |=> rgo_o);
  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lack_o, exec_o, done_o}));
  // R8
  lexec_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> lexec_o);
  // R8
  lexec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lexec_o && !lexec_ack_i) |=> lexec_o);
  // R10
  last_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |-> (!rreq_o && !rgo_o && !rexec_ack_o));
endmodule

bind digit_seq_ctrl digit_seq_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .last_i(last_i), .lack_o(lack_o),
  .lgo_i(lgo_i), .lgo_ack_o(lgo_ack_o), .lexec_o(lexec_o),
  .lexec_ack_i(lexec_ack_i), .rreq_o(rreq_o), .rop_o(rop_o),
  .rmod_o(rmod_o), .rack_i(rack_i), .rexec_ack_o(rexec_ack_o),
  .rgo_o(rgo_o), .rgo_ack_i(rgo_ack_i), .exec_o(exec_o),
  .done_o(done_o), .right_ready_w(right_ready_w)
);

// File: tb/digit_seq_ctrl_test.sv
module digit_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic last_i = 1'b0;
  logic [DW-1:0] dig_a_i = '0, dig_b_i = '0, lmod_i = '0;
  logic [1:0] lop_i = '0;
  logic lreq_i = 0, lgo_i = 0, lexec_ack_i = 0, rack_i = 0, rexec_i = 0, rgo_ack_i = 0;
  logic lack_o, lgo_ack_o, lexec_o, rreq_o, rexec_ack_o, rgo_o, exec_o, done_o;
  logic [1:0] rop_o, exec_op_o;
  logic [DW-1:0] rmod_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  digit_seq_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .last_i(last_i), .dig_a_i(dig_a_i), .dig_b_i(dig_b_i),
    .lreq_i(lreq_i), .lop_i(lop_i), .lmod_i(lmod_i), .lack_o(lack_o),
    .lgo_i(lgo_i), .lgo_ack_o(lgo_ack_o), .lexec_o(lexec_o), .lexec_ack_i(lexec_ack_i),
    .rreq_o(rreq_o), .rop_o(rop_o), .rmod_o(rmod_o), .rack_i(rack_i),
    .rexec_i(rexec_i), .rexec_ack_o(rexec_ack_o), .rgo_o(rgo_o), .rgo_ack_i(rgo_ack_i),
    .exec_o(exec_o), .exec_op_o(exec_op_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // expected modifier, written as arithmetic on the code value
  function automatic logic [DW-1:0] ref_mod(input int op, input logic [DW-1:0] m,
                                            input logic [DW-1:0] a, input logic [DW-1:0] b);
    int s;
    if (op == 0)      s = m;
    else if (op == 1) s = a;
    else if (op == 2) s = (m + b) % (1 << DW);
    else              s = b;
    return s[DW-1:0];
  endfunction

  // one microinstruction with the bench playing both neighbours; starts idle
  task automatic run_instr(input int op, input int m, input int a, input int b,
                           input bit need_rexec, input int gdelay);
    logic [DW-1:0] em;
    em = ref_mod(op, DW'(m), DW'(a), DW'(b));
    @(negedge clk);
    lop_i = 2'(op); lmod_i = DW'(m); dig_a_i = DW'(a); dig_b_i = DW'(b); lreq_i = 1;
    #1 chk(lack_o == 1, "R2", "lack on accept", lack_o, 1);
    @(negedge clk);
    lreq_i = 0;
    dig_a_i = ~dig_a_i; dig_b_i = ~dig_b_i;
    chk(rreq_o == 1, "R4", "rreq after accept", rreq_o, 1);
    chk(rop_o == 2'(op), "R4", "rop", rop_o, op);
    chk(rmod_o == em, "R3", "rmod", rmod_o, em);
    @(negedge clk);
    chk(rreq_o == 1 && rmod_o == em, "R4", "rreq held", rreq_o, 1);
    rack_i = 1;
    @(negedge clk);
    rack_i = 0;
    chk(rreq_o == 0, "R4", "rreq dropped", rreq_o, 0);
    for (int i = 0; i < gdelay; i++) begin
      #1 chk(exec_o == 0, "R6", "no exec without lgo", exec_o, 0);
      @(negedge clk);
    end
    if (need_rexec) begin
      lgo_i = 1;
      #1 chk(exec_o == 0, "R5", "exec blocked before right report", exec_o, 0);
      rexec_i = 1;
      #1 chk(rexec_ack_o == 1, "R9", "rexec ack", rexec_ack_o, 1);
      @(negedge clk);
      rexec_i = 0;
    end
    lgo_i = 1;
    #1 chk(exec_o == 1 && lgo_ack_o == 1, "R6", "exec strobe", exec_o, 1);
    chk(exec_op_o == 2'(op), "R11", "exec code", exec_op_o, op);
    @(negedge clk);
    lgo_i = 0;
    chk(exec_o == 0, "R6", "exec one cycle", exec_o, 0);
    chk(lexec_o == 1, "R8", "lexec set", lexec_o, 1);
    chk(rgo_o == 1 && done_o == 0, "R7", "rgo raised", rgo_o, 1);
    @(negedge clk);
    chk(rgo_o == 1, "R7", "rgo held", rgo_o, 1);
    rgo_ack_i = 1;
    #1 chk(done_o == 1, "R7", "done pulse", done_o, 1);
    @(negedge clk);
    rgo_ack_i = 0;
    chk(rgo_o == 0 && done_o == 0, "R7", "back to idle", rgo_o, 0);
  endtask

  task automatic ack_lexec();
    @(negedge clk);
    lexec_ack_i = 1;
    @(negedge clk);
    lexec_ack_i = 0;
    chk(lexec_o == 0, "R8", "lexec cleared", lexec_o, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5eed_0d1c);
    repeat (2) @(negedge clk);
    // R1 during and after reset
    chk({lack_o, rreq_o, rgo_o, lexec_o, exec_o, done_o, lgo_ack_o, rexec_ack_o} == 0,
        "R1", "outputs in reset", 1, 0);
    rst_n = 1;
    @(negedge clk);
    chk({lack_o, rreq_o, rgo_o, lexec_o, exec_o, done_o} == 0, "R1", "outputs idle", 1, 0);

    // first microinstruction needs no right report
    run_instr(1, 5, 9, 3, 0, 2);
    // R8: notice still pending while the next microinstruction runs
    @(negedge clk);
    chk(lexec_o == 1, "R8", "lexec persists", lexec_o, 1);
    // R2: busy controller ignores a request
    @(negedge clk);
    lop_i = 2'd2; lmod_i = 4'd7; lreq_i = 1;
    #1 chk(lack_o == 1, "R2", "accept second", lack_o, 1);
    @(negedge clk);
    chk(lexec_o == 1, "R8", "lexec across accept", lexec_o, 1);
    #1 chk(lack_o == 0, "R2", "busy no ack", lack_o, 0);
    rack_i = 1;
    @(negedge clk);
    rack_i = 0;
    lreq_i = 0;
    lgo_i = 1;
    #1 chk(exec_o == 0, "R5", "waits for right", exec_o, 0);
    @(negedge clk);
    chk(exec_o == 0, "R5", "still waiting", exec_o, 0);
    rexec_i = 1;
    @(negedge clk);
    rexec_i = 0;
    #1 chk(exec_o == 1 && exec_op_o == 2, "R5", "exec after report", exec_op_o, 2);
    @(negedge clk);
    lgo_i = 0;
    rgo_ack_i = 1;
    @(negedge clk);
    rgo_ack_i = 0;
    ack_lexec();

    // R11 multiplication groups 1,2,1 twice
    for (int g = 0; g < 2; g++) begin
      run_instr(1, g, 3, 4, 1, 0);
      run_instr(2, 6 + g, 2, 11, 1, 1);
      run_instr(1, 15, 12, 1, 1, 0);
    end
    ack_lexec();

    // corner: multiply-add wrap
    run_instr(2, 15, 0, 15, 1, 0);
    run_instr(0, 10, 1, 2, 1, 0);
    run_instr(3, 10, 1, 13, 1, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      run_instr($urandom % 4, $urandom % 16, $urandom % 16, $urandom % 16, 1, $urandom % 3);
      if ($urandom % 2) ack_lexec();
    end
    ack_lexec();

    // R10 least significant module
    @(negedge clk);
    last_i = 1;
    lgo_i = 1;
    lop_i = 2'd3; lmod_i = 4'd1; dig_b_i = 4'd6; lreq_i = 1;
    #1 chk(lack_o == 1, "R10", "accept in last", lack_o, 1);
    @(negedge clk);
    lreq_i = 0;
    chk(rreq_o == 0 && exec_o == 0, "R10", "no rreq", rreq_o, 0);
    @(negedge clk);
    chk(exec_o == 1, "R10", "exec two after accept", exec_o, 1);
    chk(rexec_ack_o == 0, "R10", "no rexec ack", rexec_ack_o, 0);
    @(negedge clk);
    chk(done_o == 1 && rgo_o == 0, "R10", "done no rgo", done_o, 1);
    @(negedge clk);
    chk(done_o == 0, "R10", "idle again", done_o, 0);
    lgo_i = 0;
    finish_run();
  end
endmodule